// File: doc/BRIEF.md
# Banked nibble RAM access controller

This block sits between a processor's data-memory port and a 4-bit-wide on-chip store of 1,184 words. Each request carries a 10-bit digit address, an operation code, a bit index and write data. The block works out which region the address falls in and checks whether that operation is allowed there. It then either carries out the access on the internal store, routes it to the special-function-register bus, applies it to an internal file of control and flag bits, or rejects it with an error pulse. A separate read-only port gives the segment driver the display words at any time.

The window $100–$2CF exists twice, and a bank-select input picks which copy is reached. The other RAM regions are $040–$0FF and $3C0–$3FF, and they are not banked. Addresses $2D0–$3BF map to nothing. Some flags follow special rules. Interrupt request bits can be set only by hardware. The watchdog-enable flag is set-only. The display-timing flag is held clear whenever the operating mode is active.

Top module: `nibble_bank_ram`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid and rsp_err are 0, int_bits and flag_bits are all 0, and every RAM word reads 0.
- R2: Operation codes are 0 read, 1 write, 2 bit set, 3 bit reset and 4 bit test. In the RAM regions $040–$0FF, $100–$2CF and $3C0–$3FF, a read or write requested in cycle N gives rsp_valid, and for a read rsp_data, in cycle N+1. A write is seen by any later read.
- R3: Addresses $100–$2CF reach bank 0 when bank_sel=0 and bank 1 when bank_sel=1, and the two banks hold independent words. bank_sel has no effect on any other address.
- R4: In the RAM regions, bit set and bit reset change only bit req_bit of the word. Bit test returns that bit in rsp_data[0], with rsp_data[3:1]=0.
- R5: Addresses $000–$003 hold 16 interrupt-control bits, where int_bits index = 4*(addr[1:0])+req_bit. Plain read or write there is illegal. Bit set, bit reset and bit test are allowed. Odd indices are request flags: a software bit set on one has no effect, and irq_hw[i]=1 sets it in the following cycle.
- R6: A plain access to a special-function register ($004–$01F, $024–$03F) drives sfr_addr=addr[5:0] in the same cycle. The register classes are: read-only at $004–$00B, write-only at $024–$02F, and read/write elsewhere. A write to a read-only register raises an error and gives no sfr_wr_en. A read of a write-only register returns 0 and gives no sfr_rd_en.
- R7: Among the special-function registers, only the display control register at $01C accepts bit set and bit reset. These work as a read-modify-write over the register bus. Every other bit operation on a special-function register, and bit test on $01C, is illegal.
- R8: Flags at $020–$023 appear on flag_bits[addr[1:0]] and are reached only by bit operations on bit 0. A plain access there is illegal. Bit reset has no effect on the watchdog flag ($021).
- R9: The display-timing flag ($023, flag_bits[3]) is cleared in the cycle after mode_sub=0 is seen, and a set has no effect while mode_sub=0. With mode_sub=1 it can be set, reset and tested.
- R10: disp_data returns the word at $050+disp_addr one cycle after disp_addr is applied, independent of any concurrent processor access.
- R11: Addresses $2D0–$3BF read and test as 0, ignore writes and raise no error.
- R12: An illegal access, or an operation code of 5 to 7, gives rsp_err=1 with rsp_data=0 in the response cycle and changes no memory, register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | 10 | Digit address |
| req_bit | input | 2 | Bit index for bit operations |
| req_wdata | input | 4 | Write data |
| bank_sel | input | 1 | Bank for the $100–$2CF window |
| mode_sub | input | 1 | 1 = subactive mode, 0 = active mode |
| irq_hw | input | 16 | Hardware set pulses for interrupt request bits |
| disp_addr | input | 5 | Display word index |
| sfr_rdata | input | 4 | Register bus read data, combinational on sfr_addr |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | 4 | Read data or test bit |
| rsp_err | output | 1 | Illegal access pulse |
| disp_data | output | 4 | Display word |
| sfr_wr_en | output | 1 | Register bus write strobe |
| sfr_rd_en | output | 1 | Register bus read strobe |
| sfr_addr | output | 6 | Register bus address |
| sfr_wdata | output | 4 | Register bus write data |
| int_bits | output | 16 | Interrupt control bits |
| flag_bits | output | 4 | Special flags |

## Verification
Some rules are checked by assertions on every cycle. The watchdog flag never falls. The display-timing flag is clear after any active-mode cycle. No interrupt request bit rises without a hardware pulse. An error response carries zero data. A read-only register never gets a write strobe. Other behaviour can only be shown by the bench's scenarios, because it needs a known history: bank independence, the read-modify-write on the display control register, display-port data under concurrent traffic, and memory left unchanged after rejected accesses.

// File: rtl/nbr_pkg.sv
// Package: shared map constants, operation and region types for the
// banked nibble RAM controller. Assumes a 10-bit digit address space.
package nbr_pkg;
    localparam int ADDR_W      = 10;
    localparam int DATA_W      = 4;
    localparam int BIT_W       = 2;
    localparam int SFR_AW      = 6;
    localparam int INT_WORDS   = 4;
    localparam int INT_BITS    = INT_WORDS * DATA_W;
    localparam int FLAG_BASE   = 'h020;
    localparam int FLAG_LAST   = 'h023;
    localparam int SFR_A_BASE  = 'h004;
    localparam int SFR_A_LAST  = 'h01F;
    localparam int SFR_B_BASE  = 'h024;
    localparam int SFR_B_LAST  = 'h03F;
    localparam int RO_BASE     = 'h004;
    localparam int RO_LAST     = 'h00B;
    localparam int WO_BASE     = 'h024;
    localparam int WO_LAST     = 'h02F;
    localparam int LCR_ADDR    = 'h01C;
    localparam int LOW_BASE    = 'h040;
    localparam int LOW_LAST    = 'h0FF;
    localparam int WIN_BASE    = 'h100;
    localparam int WIN_LAST    = 'h2CF;
    localparam int STK_BASE    = 'h3C0;
    localparam int STK_LAST    = 'h3FF;
    localparam int DISP_BASE   = 'h050;
    localparam int DISP_AW     = 5;
    localparam int LOW_SZ      = LOW_LAST - LOW_BASE + 1;
    localparam int WIN_SZ      = WIN_LAST - WIN_BASE + 1;
    localparam int STK_SZ      = STK_LAST - STK_BASE + 1;
    localparam int MEM_DEPTH   = LOW_SZ + 2 * WIN_SZ + STK_SZ;
    localparam int IDX_W       = $clog2(MEM_DEPTH);

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_SET   = 3'd2,
        OP_CLR   = 3'd3,
        OP_TEST  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_INT, RG_SFR, RG_FLAG, RG_RAM
    } region_e;

    typedef enum logic [1:0] {
        SC_RW, SC_RO, SC_WO
    } sfr_cls_e;

    // Access class of a special-function register by its low address bits.
    function automatic sfr_cls_e sfr_class(input logic [SFR_AW-1:0] a);
        int v;
        v = int'(a);
        if (v >= RO_BASE && v <= RO_LAST)      return SC_RO;
        else if (v >= WO_BASE && v <= WO_LAST) return SC_WO;
        else                                   return SC_RW;
    endfunction
endpackage

// File: rtl/nbr_decode.sv
// Address decoder: classifies a digit address into a region and, for RAM
// regions, computes the physical word index including the bank offset.
// Assumes the physical store lays out low area, bank 0, bank 1, stack area.
module nbr_decode
    import nbr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    int a;

    // Region classification and physical index computation.
    always_comb begin
        a      = int'(addr);
        region = RG_NONE;
        idx    = '0;
        if (a < INT_WORDS) begin
            region = RG_INT;
        end else if (a >= FLAG_BASE && a <= FLAG_LAST) begin
            region = RG_FLAG;
        end else if ((a >= SFR_A_BASE && a <= SFR_A_LAST) ||
                     (a >= SFR_B_BASE && a <= SFR_B_LAST)) begin
            region = RG_SFR;
        end else if (a >= LOW_BASE && a <= LOW_LAST) begin
            region = RG_RAM;
            idx    = IDX_W'(a - LOW_BASE);
        end else if (a >= WIN_BASE && a <= WIN_LAST) begin
            region = RG_RAM;
            idx    = IDX_W'(LOW_SZ + (a - WIN_BASE) + (bank ? WIN_SZ : 0));
        end else if (a >= STK_BASE && a <= STK_LAST) begin
            region = RG_RAM;
            idx    = IDX_W'(LOW_SZ + 2 * WIN_SZ + (a - STK_BASE));
        end
    end
endmodule

// File: rtl/nbr_store.sv
// Physical nibble store: one combinational read / synchronous write port
// for the processor side and one registered read port for the display.
// Assumes a flop array cleared by reset.
module nbr_store
    import nbr_pkg::*;
#(
    parameter int DEPTH = MEM_DEPTH,
    parameter int DISP_OFS = DISP_BASE - LOW_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [DISP_AW-1:0] disp_addr,
    output logic [DATA_W-1:0]  disp_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Processor-side read, guarded against indices beyond the store.
    always_comb begin
        rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;
    end

    // Array write and reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && int'(idx) < DEPTH) begin
            mem[idx] <= wdata;
        end
    end

    // Registered display read port.
    always_ff @(posedge clk) begin
        if (!rst_n) disp_data <= '0;
        else        disp_data <= mem[DISP_OFS + int'(disp_addr)];
    end
endmodule

// File: rtl/nbr_flags.sv
// Interrupt-control bit file and special flag register. Applies the
// set-only, hardware-only-set and mode-forced-clear rules. Assumes the
// caller only asserts wr_en for legal bit set/reset requests.
module nbr_flags
    import nbr_pkg::*;
#(
    parameter logic [INT_BITS-1:0] IRQ_REQ_MASK = 16'hAAAA,
    parameter int NUM_FLAGS = 4,
    parameter int WDT_IDX   = 1,
    parameter int DTIM_IDX  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_sub,
    input  logic [INT_BITS-1:0]  irq_hw,
    input  logic                 wr_en,
    input  logic                 set_op,
    input  logic                 sel_int,
    input  logic                 sel_flag,
    input  logic [1:0]           word,
    input  logic [BIT_W-1:0]     bitn,
    output logic                 test_bit,
    output logic [INT_BITS-1:0]  int_bits,
    output logic [NUM_FLAGS-1:0] flag_bits
);
    logic [3:0] ibit;
    assign ibit = {word, bitn};

    // Test-bit selection for the addressed interrupt bit or flag.
    always_comb begin
        test_bit = 1'b0;
        if (sel_int)                       test_bit = int_bits[ibit];
        else if (sel_flag && bitn == '0)   test_bit = flag_bits[word];
    end

    // Interrupt bits: software set blocked on request flags, hardware set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_bits <= '0;
        end else begin
            for (int i = 0; i < INT_BITS; i++) begin
                if (IRQ_REQ_MASK[i] && irq_hw[i])
                    int_bits[i] <= 1'b1;
                else if (wr_en && sel_int && int'(ibit) == i)
                    int_bits[i] <= set_op ? (int_bits[i] | ~IRQ_REQ_MASK[i]) : 1'b0;
            end
        end
    end

    // Special flags: watchdog set-only, display timing held clear in active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_bits <= '0;
        end else begin
            for (int i = 0; i < NUM_FLAGS; i++) begin
                if (i == DTIM_IDX && !mode_sub)
                    flag_bits[i] <= 1'b0;
                else if (wr_en && sel_flag && bitn == '0 && int'(word) == i) begin
                    if (set_op)            flag_bits[i] <= 1'b1;
                    else if (i != WDT_IDX) flag_bits[i] <= 1'b0;
                end
            end
        end
    end

    // R8: the watchdog flag never falls once set.
    assert_wdt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_bits[WDT_IDX] |=> flag_bits[WDT_IDX]);

    // R9: active mode forces the display-timing flag clear.
    assert_dtim_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sub |=> !flag_bits[DTIM_IDX]);

    // R5: request flags only rise after a hardware pulse.
    for (genvar g = 0; g < INT_BITS; g++) begin : g_req
        if (IRQ_REQ_MASK[g]) begin : g_chk
            assert_irq_hw_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!int_bits[g] && !irq_hw[g]) |=> !int_bits[g]);
        end
    end
endmodule

// File: rtl/nibble_bank_ram.sv
// Top: banked nibble RAM access controller. Decodes each request, applies
// region/operation permissions, steers it to the store, the register bus or
// the flag file, and registers a one-cycle response. Assumes the register
// bus returns sfr_rdata combinationally for the current sfr_addr.
module nibble_bank_ram
    import nbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [BIT_W-1:0]     req_bit,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 bank_sel,
    input  logic                 mode_sub,
    input  logic [INT_BITS-1:0]  irq_hw,
    input  logic [DISP_AW-1:0]   disp_addr,
    input  logic [DATA_W-1:0]    sfr_rdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_data,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    disp_data,
    output logic                 sfr_wr_en,
    output logic                 sfr_rd_en,
    output logic [SFR_AW-1:0]    sfr_addr,
    output logic [DATA_W-1:0]    sfr_wdata,
    output logic [INT_BITS-1:0]  int_bits,
    output logic [3:0]           flag_bits
);
    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem_rdata, mem_wdata, cur, modified;
    logic              mem_we, fl_we, fl_test;
    logic              is_read, is_write, is_set, is_clr, is_test, is_bitop;
    logic              legal, is_lcr;
    sfr_cls_e          cls;
    logic [DATA_W-1:0] rsp_next;

    nbr_decode u_decode (.addr(req_addr), .bank(bank_sel), .region(region), .idx(idx));

    nbr_store u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx), .we(mem_we), .wdata(mem_wdata),
        .rdata(mem_rdata), .disp_addr(disp_addr), .disp_data(disp_data)
    );

    nbr_flags u_flags (
        .clk(clk), .rst_n(rst_n), .mode_sub(mode_sub), .irq_hw(irq_hw),
        .wr_en(fl_we), .set_op(is_set),
        .sel_int(region == RG_INT), .sel_flag(region == RG_FLAG),
        .word(req_addr[1:0]), .bitn(req_bit), .test_bit(fl_test),
        .int_bits(int_bits), .flag_bits(flag_bits)
    );

    // Operation-code classification.
    always_comb begin
        is_read  = req_op == OP_READ;
        is_write = req_op == OP_WRITE;
        is_set   = req_op == OP_SET;
        is_clr   = req_op == OP_CLR;
        is_test  = req_op == OP_TEST;
        is_bitop = is_set || is_clr || is_test;
    end

    assign sfr_addr = req_addr[SFR_AW-1:0];
    assign cls      = sfr_class(sfr_addr);
    assign is_lcr   = int'(req_addr) == LCR_ADDR;

    // Permission check per region and operation.
    always_comb begin
        case (region)
            RG_INT, RG_FLAG: legal = is_bitop;
            RG_SFR:          legal = is_read || (is_write && cls != SC_RO) ||
                                     ((is_set || is_clr) && is_lcr);
            default:         legal = is_read || is_write || is_bitop;
        endcase
    end

    // Current word for read-modify-write and its bit-modified value.
    always_comb begin
        cur      = (region == RG_SFR) ? sfr_rdata : mem_rdata;
        modified = is_set ? (cur | (DATA_W'(1) << req_bit))
                          : (cur & ~(DATA_W'(1) << req_bit));
    end

    // Write steering to store, register bus and flag file.
    always_comb begin
        mem_we    = req_valid && legal && region == RG_RAM && (is_write || is_set || is_clr);
        mem_wdata = is_write ? req_wdata : modified;
        sfr_wr_en = req_valid && legal && region == RG_SFR && !is_read;
        sfr_wdata = is_write ? req_wdata : modified;
        sfr_rd_en = req_valid && legal && region == RG_SFR &&
                    ((is_read && cls != SC_WO) || is_set || is_clr);
        fl_we     = req_valid && legal && (region == RG_INT || region == RG_FLAG) &&
                    (is_set || is_clr);
    end

    // Response data selection.
    always_comb begin
        rsp_next = '0;
        if (legal) begin
            case (region)
                RG_RAM:  rsp_next = is_read ? mem_rdata :
                                    is_test ? DATA_W'(mem_rdata[req_bit]) : '0;
                RG_SFR:  rsp_next = (is_read && cls != SC_WO) ? sfr_rdata : '0;
                RG_INT, RG_FLAG: rsp_next = is_test ? DATA_W'(fl_test) : '0;
                default: rsp_next = '0;
            endcase
        end
    end

    // One-cycle registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_data  <= req_valid ? rsp_next : '0;
        end
    end

    // R12: an error response carries no data.
    assert_err_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_data == '0));

    // R6: a read-only register never receives a plain write strobe.
    assert_ro_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr_en && req_op == OP_WRITE) |-> (sfr_class(sfr_addr) != SC_RO));

    // R11: unmapped addresses never reach the store.
    assert_unmapped_no_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_addr) > WIN_LAST && int'(req_addr) < STK_BASE) |-> !mem_we);
endmodule

// File: tb/nibble_bank_ram_bench.sv
module nibble_bank_ram_bench;
    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [2:0] req_op = 0;
    logic [9:0] req_addr = 0;
    logic [1:0] req_bit = 0;
    logic [3:0] req_wdata = 0;
    logic bank_sel = 0, mode_sub = 0;
    logic [15:0] irq_hw = 0;
    logic [4:0] disp_addr = 0;
    logic [3:0] sfr_rdata;
    logic rsp_valid, rsp_err, sfr_wr_en, sfr_rd_en;
    logic [3:0] rsp_data, disp_data, sfr_wdata, flag_bits;
    logic [5:0] sfr_addr;
    logic [15:0] int_bits;

    logic [3:0] sfr_model [64];
    logic pre_en = 0;
    logic [5:0] pre_addr = 0;
    logic [3:0] pre_val = 0;
    logic [3:0] ref_mem [2048];
    int checks = 0, errors = 0;
    logic [3:0] r_data;
    logic r_err, r_valid;

    always #2 clk = ~clk;

    nibble_bank_ram u_nibble_bank_ram (.*);

    assign sfr_rdata = sfr_model[sfr_addr];
    always @(posedge clk) begin
        if (pre_en) sfr_model[pre_addr] <= pre_val;
        else if (sfr_wr_en) sfr_model[sfr_addr] <= sfr_wdata;
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic req(int op, int addr, int b, int wd);
        req_valid = 1; req_op = 3'(op); req_addr = 10'(addr);
        req_bit = 2'(b); req_wdata = 4'(wd);
        @(negedge clk);
        r_data = rsp_data; r_err = rsp_err; r_valid = rsp_valid;
        req_valid = 0;
    endtask

    task automatic preload(int a, int v);
        pre_en = 1; pre_addr = 6'(a); pre_val = 4'(v);
        @(negedge clk);
        pre_en = 0;
    endtask

    function automatic bit in_win(int a);
        return a >= 'h100 && a <= 'h2CF;
    endfunction

    function automatic bit in_ram(int a);
        return (a >= 'h040 && a <= 'h2CF) || (a >= 'h3C0 && a <= 'h3FF);
    endfunction

    function automatic int ref_key(int a, int b);
        return (in_win(a) ? b : 0) * 1024 + a;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) sfr_model[i] = 0;
        for (int i = 0; i < 2048; i++) ref_mem[i] = 0;
        void'($urandom(32'h1357));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 rsp_err", rsp_err, 0);
        check("R1 int_bits", int_bits, 0);
        check("R1 flag_bits", flag_bits, 0);
        req(0, 'h3C5, 0, 0);
        check("R1 ram read", r_data, 0);

        // R2 R3 R4 R11 random traffic against the reference model
        for (int i = 0; i < 800; i++) begin
            int sel, a, op, b, wd, k, e;
            sel = $urandom % 4;
            case (sel)
                0: a = 'h040 + $urandom % 192;
                1: a = 'h100 + $urandom % 464;
                2: a = 'h3C0 + $urandom % 64;
                default: a = 'h2D0 + $urandom % 240;
            endcase
            bank_sel = 1'($urandom % 2);
            op = $urandom % 5; b = $urandom % 4; wd = $urandom % 16;
            k = ref_key(a, int'(bank_sel));
            e = 0;
            if (in_ram(a)) begin
                case (op)
                    0: e = ref_mem[k];
                    1: ref_mem[k] = 4'(wd);
                    2: ref_mem[k] = ref_mem[k] | 4'(1 << b);
                    3: ref_mem[k] = ref_mem[k] & ~4'(1 << b);
                    default: e = int'(ref_mem[k][b]);
                endcase
            end
            req(op, a, b, wd);
            check("R2 rsp_valid", r_valid, 1);
            check("R11 no err", r_err, 0);
            if (op == 0 || op == 4) check(in_ram(a) ? "R4 R3 data" : "R11 data", r_data, e);
        end

        // R3 directed bank independence and unbanked addresses
        bank_sel = 0; req(1, 'h200, 0, 5);
        bank_sel = 1; req(1, 'h200, 0, 'hA);
        bank_sel = 0; req(0, 'h200, 0, 0); check("R3 bank0", r_data, 5);
        bank_sel = 1; req(0, 'h200, 0, 0); check("R3 bank1", r_data, 'hA);
        bank_sel = 0; req(1, 'h0FF, 0, 7);
        bank_sel = 1; req(0, 'h0FF, 0, 0); check("R3 unbanked", r_data, 7);

        // R11 unmapped write ignored
        req(1, 'h300, 0, 'hF); req(0, 'h300, 0, 0);
        check("R11 unmapped read", r_data, 0); check("R11 unmapped err", r_err, 0);

        // R10 display port with concurrent access
        req(1, 'h053, 0, 9);
        disp_addr = 3; req(1, 'h060, 0, 4);
        check("R10 disp", disp_data, 9);
        disp_addr = 16; @(negedge clk);
        check("R10 disp2", disp_data, 4);

        // R5 R12 interrupt area
        req(1, 'h000, 0, 'hF); check("R12 int plain err", r_err, 1);
        check("R12 int unchanged", int_bits, 0);
        req(2, 'h000, 1, 0); check("R5 sw set req flag", int_bits, 0);
        req(2, 'h001, 0, 0); check("R5 sw set enable", int_bits, 16'h0010);
        irq_hw = 16'h0002; @(negedge clk); irq_hw = 0;
        check("R5 hw set", int_bits, 16'h0012);
        req(4, 'h000, 1, 0); check("R5 test", r_data, 1);
        req(3, 'h000, 1, 0); check("R5 clear", int_bits, 16'h0010);

        // R6 register bus classes
        preload('h05, 7);
        req(1, 'h005, 0, 2); check("R6 ro write err", r_err, 1);
        req(0, 'h005, 0, 0); check("R6 ro read", r_data, 7);
        req(1, 'h024, 0, 3); check("R6 wo model", sfr_model['h24], 3);
        req(0, 'h024, 0, 0); check("R6 wo read zero", r_data, 0);
        req(1, 'h00C, 0, 6); req(0, 'h00C, 0, 0); check("R6 rw", r_data, 6);

        // R7 display control register bit operations
        req(1, 'h01C, 0, 2); req(2, 'h01C, 0, 0); check("R7 lcr set err", r_err, 0);
        req(0, 'h01C, 0, 0); check("R7 lcr set", r_data, 3);
        req(3, 'h01C, 1, 0); req(0, 'h01C, 0, 0); check("R7 lcr clr", r_data, 1);
        req(2, 'h00C, 0, 0); check("R7 other bitop err", r_err, 1);
        req(0, 'h00C, 0, 0); check("R7 other unchanged", r_data, 6);
        req(4, 'h01C, 0, 0); check("R7 lcr test err", r_err, 1);

        // R8 flags
        req(0, 'h020, 0, 0); check("R8 plain err", r_err, 1);
        req(2, 'h021, 0, 0); check("R8 wdt set", flag_bits[1], 1);
        req(3, 'h021, 0, 0); check("R8 wdt sticky", flag_bits[1], 1);
        req(2, 'h020, 0, 0); check("R8 flag set", flag_bits[0], 1);
        req(3, 'h020, 0, 0); check("R8 flag clr", flag_bits[0], 0);

        // R9 display-timing flag vs mode
        mode_sub = 0; req(2, 'h023, 0, 0); check("R9 active set", flag_bits[3], 0);
        mode_sub = 1; req(2, 'h023, 0, 0); check("R9 sub set", flag_bits[3], 1);
        req(4, 'h023, 0, 0); check("R9 sub test", r_data, 1);
        mode_sub = 0; @(negedge clk); check("R9 forced clear", flag_bits[3], 0);

        // R12 reserved op code
        req(5, 'h040, 0, 0); check("R12 bad op err", r_err, 1);
        check("R12 bad op data", r_data, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule